// File: doc/BRIEF.md
# I2C Interrupt Status, Mask and Vector Unit

This unit sits beside an I2C controller's bus engine and turns the engine's one-cycle event pulses into sticky status flags. Seven events are tracked: arbitration lost, NACK received, access ready, receive data ready, transmit data ready, stop condition seen and addressed as a target. Software sees the flags in a status register and enables the ones it cares about in a mask register. The single interrupt line is high while any flag is both set and enabled.

A vector register reports a code from 1 to 7 for the enabled pending event with the smallest code, and 0 when there is none. Reading the vector also retires the flag it names, so an interrupt handler can loop on vector reads until it sees 0. Software can also clear flags by writing ones to the status register. The receive-ready flag clears when the receive data register is read, and the transmit-ready flag clears when the transmit data register is written. Two level inputs from the bus engine, receive shift full and bus busy, are mirrored into the status word.

The register port is a plain single-cycle strobe interface. Read data is combinational from the address. A read strobe only matters for the vector's clear side effect.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: After reset every flag is clear, the mask reads 0x0000, the vector reads 0 and `irq` is low.
- R2: A pulse on `evt_i[k]` sets status bit k on the next clock. The bits are: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop seen, 6 addressed as target.
- R3: A write to the status register (offset 0x08) clears every flag whose data bit is 1 and leaves flags written with 0 unchanged.
- R4: The mask register at offset 0x04 stores bits 6:0 of the write data, using the same bit positions as R2. Its bits 15:7 read 0.
- R5: `irq` is high exactly when some flag is set and its mask bit is 1. A masked flag is still visible in the status register.
- R6: The vector register at offset 0x28 reads k+1 for the lowest-numbered enabled pending flag k. Code 1 has the highest priority. The vector reads 0 when no enabled flag is pending.
- R7: A read strobe at the vector offset clears the flag the vector reported. A read that returns 0 changes no flag.
- R8: `rxdata_rd` clears the receive-ready flag (bit 3), and `txdata_wr` clears the transmit-ready flag (bit 4).
- R9: If an event pulse and any clear of the same flag fall in the same cycle, the flag ends up set.
- R10: Status bit 11 mirrors `rx_full_i` and bit 12 mirrors `bus_busy_i`. Status writes have no effect on these two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 7 | One-cycle event pulses, bit order as in R2 |
| rx_full_i | input | 1 | Receive shift register full (level) |
| bus_busy_i | input | 1 | Bus busy (level) |
| rxdata_rd | input | 1 | Strobe: receive data register was read |
| txdata_wr | input | 1 | Strobe: transmit data register was written |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things. First, that `irq` agrees with the flags and the mask. Second, that the vector is zero exactly when nothing enabled is pending. Third, that an event pulse always leaves its flag set, even against a clear in the same cycle. Fourth, that a status write or a top-priority vector read retires its flag. Only the bench's scenarios show the rest: the full priority order across mixed event and mask patterns, a vector-read loop that walks every code down to 0, the data-path clears, and the mirrored level bits.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int NEV     = 7;
  localparam int EV_ARB  = 0;
  localparam int EV_NAK  = 1;
  localparam int EV_ACC  = 2;
  localparam int EV_RXR  = 3;
  localparam int EV_TXR  = 4;
  localparam int EV_STP  = 5;
  localparam int EV_TGT  = 6;
  localparam int BIT_RXFULL = 11;
  localparam int BIT_BUSY   = 12;
  localparam int OFF_MASK = 'h04;
  localparam int OFF_STAT = 'h08;
  localparam int OFF_VEC  = 'h28;
  localparam int CODE_W   = $clog2(NEV + 1);
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NEV = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] set_i,
  input  logic [NEV-1:0] clr_i,
  output logic [NEV-1:0] flags_o
);
  for (genvar k = 0; k < NEV; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_o[k] <= 1'b0;
      else if (set_i[k])   flags_o[k] <= 1'b1;
      else if (clr_i[k])   flags_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NEV = 7,
  parameter int CW  = 3
) (
  input  logic [NEV-1:0] pend_i,
  output logic [CW-1:0]  code_o
);
  always_comb begin
    code_o = '0;
    for (int k = NEV - 1; k >= 0; k--) begin
      if (pend_i[k]) code_o = CW'(k + 1);
    end
  end
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEV-1:0]    evt_i,
  input  logic              rx_full_i,
  input  logic              bus_busy_i,
  input  logic              rxdata_rd,
  input  logic              txdata_wr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [NEV-1:0]    flags;
  logic [NEV-1:0]    mask_q;
  logic [NEV-1:0]    clr;
  logic [NEV-1:0]    pend;
  logic [CODE_W-1:0] vec_code;
  logic sel_mask, sel_stat, sel_vec;

  assign sel_mask = (reg_addr == ADDR_W'(OFF_MASK));
  assign sel_stat = (reg_addr == ADDR_W'(OFF_STAT));
  assign sel_vec  = (reg_addr == ADDR_W'(OFF_VEC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 mask_q <= '0;
    else if (reg_wr && sel_mask) mask_q <= reg_wdata[NEV-1:0];
  end

  for (genvar k = 0; k < NEV; k++) begin : g_clr
    logic side;
    if (k == EV_RXR)      begin : g_rx assign side = rxdata_rd; end
    else if (k == EV_TXR) begin : g_tx assign side = txdata_wr; end
    else                  begin : g_no assign side = 1'b0;      end
    assign clr[k] = (reg_wr && sel_stat && reg_wdata[k])
                  | (reg_rd && sel_vec && vec_code == CODE_W'(k + 1))
                  | side;
  end

  irq_flag_bank #(.NEV(NEV)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(clr), .flags_o(flags)
  );

  assign pend = flags & mask_q;

  irq_prio_enc #(.NEV(NEV), .CW(CODE_W)) u_prio (
    .pend_i(pend), .code_o(vec_code)
  );

  assign irq = |pend;

  always_comb begin
    reg_rdata = '0;
    if (sel_mask) begin
      reg_rdata[NEV-1:0] = mask_q;
    end else if (sel_stat) begin
      reg_rdata[NEV-1:0]  = flags;
      reg_rdata[BIT_RXFULL] = rx_full_i;
      reg_rdata[BIT_BUSY]   = bus_busy_i;
    end else if (sel_vec) begin
      reg_rdata[CODE_W-1:0] = vec_code;
    end
  end
endmodule

// File: rtl/i2c_irq_ctrl_chk.sv
module i2c_irq_ctrl_chk
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NEV-1:0]    evt_i,
  input logic              rxdata_rd,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              irq,
  input logic [NEV-1:0]    flags,
  input logic [NEV-1:0]    mask_q,
  input logic [CODE_W-1:0] vec_code
);
  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((flags & mask_q) != '0));

  p_vec_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_code == '0) == ((flags & mask_q) == '0));

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i[EV_NAK] |=> flags[EV_NAK]);

  p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[EV_RXR] && rxdata_rd) |=> flags[EV_RXR]);

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFF_STAT) && reg_wdata[EV_ACC] && !evt_i[EV_ACC])
      |=> !flags[EV_ACC]);

  p_vec_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(OFF_VEC) && vec_code == CODE_W'(1) && !evt_i[EV_ARB])
      |=> !flags[EV_ARB]);
endmodule

bind i2c_irq_ctrl i2c_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rxdata_rd(rxdata_rd),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq(irq), .flags(flags), .mask_q(mask_q), .vec_code(vec_code)
);

// File: tb/i2c_irq_ctrl_test.sv
module i2c_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt_i = '0;
  logic        rx_full_i = 1'b0, bus_busy_i = 1'b0;
  logic        rxdata_rd = 1'b0, txdata_wr = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  int n_run = 0, n_fail = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  i2c_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rx_full_i(rx_full_i),
    .bus_busy_i(bus_busy_i), .rxdata_rd(rxdata_rd), .txdata_wr(txdata_wr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam logic [7:0] A_MASK = 8'h04, A_STAT = 8'h08, A_VEC = 8'h28;

  // {events[6:0], mask[6:0], vector[2:0], irq}
  localparam logic [17:0] TBL [8] = '{
    {7'b0000001, 7'h7F, 3'd1, 1'b1},
    {7'b1000000, 7'h7F, 3'd7, 1'b1},
    {7'b1111111, 7'h7F, 3'd1, 1'b1},
    {7'b1111111, 7'h7E, 3'd2, 1'b1},
    {7'b0110000, 7'h7F, 3'd5, 1'b1},
    {7'b0100100, 7'h20, 3'd6, 1'b1},
    {7'b0001000, 7'h00, 3'd0, 1'b0},
    {7'b0000000, 7'h7F, 3'd0, 1'b0}
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic peek(logic [7:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic rd_vec(output logic [15:0] d);
    @(negedge clk); reg_addr = A_VEC; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse(logic [6:0] e);
    @(negedge clk); evt_i = e;
    @(negedge clk); evt_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(A_STAT, rv); check("R1 status", rv, 16'h0000);
    peek(A_MASK, rv); check("R1 mask", rv, 16'h0000);
    peek(A_VEC, rv);  check("R1 vector", rv, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 R5 R6 table walk
    foreach (TBL[i]) begin
      wr(A_STAT, 16'h007F);
      wr(A_MASK, {9'd0, TBL[i][10:4]});
      pulse(TBL[i][17:11]);
      peek(A_STAT, rv); check("R2 status flags", rv, {9'd0, TBL[i][17:11]});
      peek(A_VEC, rv);  check("R6 vector code", rv, {13'd0, TBL[i][3:1]});
      check("R5 irq", {15'd0, irq}, {15'd0, TBL[i][0]});
    end

    // R3 write zero leaves flags, write one clears
    wr(A_STAT, 16'h007F);
    pulse(7'b0010110);
    wr(A_STAT, 16'h0000);
    peek(A_STAT, rv); check("R3 zero write no effect", rv, 16'h0016);
    wr(A_STAT, 16'h0004);
    peek(A_STAT, rv); check("R3 one write clears", rv, 16'h0012);

    // R4 mask upper bits read zero
    wr(A_MASK, 16'hFFFF);
    peek(A_MASK, rv); check("R4 mask readback", rv, 16'h007F);

    // R7 vector walk retires each flag in priority order
    wr(A_STAT, 16'h007F);
    pulse(7'h7F);
    for (int c = 1; c <= 7; c++) begin
      rd_vec(rv); check("R7 vector walk", rv, 16'(c));
    end
    rd_vec(rv); check("R7 vector empty", rv, 16'h0000);
    peek(A_STAT, rv); check("R7 all retired", rv, 16'h0000);

    // R7 empty vector read leaves masked flags alone
    wr(A_MASK, 16'h0000);
    pulse(7'b0000011);
    rd_vec(rv); check("R7 zero vector", rv, 16'h0000);
    peek(A_STAT, rv); check("R7 masked flags kept", rv, 16'h0003);
    check("R5 masked irq low", {15'd0, irq}, 16'h0000);

    // R8 data path clears
    wr(A_STAT, 16'h007F);
    pulse(7'b0011000);
    @(negedge clk); rxdata_rd = 1'b1; @(negedge clk); rxdata_rd = 1'b0;
    peek(A_STAT, rv); check("R8 rx clear", rv, 16'h0010);
    @(negedge clk); txdata_wr = 1'b1; @(negedge clk); txdata_wr = 1'b0;
    peek(A_STAT, rv); check("R8 tx clear", rv, 16'h0000);

    // R9 set wins over simultaneous clears
    @(negedge clk);
    evt_i = 7'b0001100; rxdata_rd = 1'b1;
    reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 16'h0004;
    @(negedge clk);
    evt_i = '0; rxdata_rd = 1'b0; reg_wr = 1'b0;
    peek(A_STAT, rv); check("R9 set wins", rv, 16'h000C);

    // R10 level mirrors, unaffected by writes
    rx_full_i = 1'b1; bus_busy_i = 1'b1;
    wr(A_STAT, 16'hFFFF);
    peek(A_STAT, rv); check("R10 levels high", rv, 16'h1800);
    rx_full_i = 1'b0;
    peek(A_STAT, rv); check("R10 rx full low", rv, 16'h1000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule